// File: doc/BRIEF.md
# Adaptive Receive Interrupt Coalescer

This block sits between a receive completion path and the processor's interrupt line. It does not interrupt software once for every received frame. Instead it counts completed frames into a batch. It raises a level interrupt request when either of two things happens first: the batch reaches a frame-count threshold, or a cycle budget has run out since the first frame of the batch. Software clears the request with a one-cycle acknowledge. The acknowledge also starts a new batch.

Two threshold sets are supplied: a small one for light traffic and a large one for heavy traffic. When adaptive selection is switched on, the block measures the load itself. It counts frames over a fixed observation window and compares that count against a high mark and a low mark. This hysteresis picks which set governs each new batch. A set is latched only at a batch boundary. When coalescing is switched off, or the thresholds make batching meaningless, each frame requests an interrupt on the following cycle.

Top module: `rx_irq_coalescer`

## Requirements
- R1: While reset is held, and on the first cycle after it, the interrupt request is low.
- R2: A frame pulse is registered on the clock edge where it is sampled. The request rises on that same edge once the pending count reaches the frame threshold that governs the batch.
- R3: If the frame threshold is not reached, the request rises exactly C clock edges after the edge that registered the first frame of the batch. C is the governing cycle threshold.
- R4: Once raised, the request stays high until an acknowledge is sampled. The acknowledge edge clears the request, the pending count and the timer.
- R5: A frame sampled on the same edge as an acknowledge becomes the first frame of the next batch.
- R6: With the coalescing enable low, each sampled frame raises the request on that edge.
- R7: A governing frame threshold of 0 or 1, or a cycle threshold of 0, makes each frame raise the request on its own edge.
- R8: With adaptive selection on, the busy set governs new batches once an observation window of WIN_CYCLES cycles counts more than HI_MARK frames. The idle set returns only after a window counts fewer than LO_MARK frames. Counts between the marks keep the current choice.
- R9: With adaptive selection off, the idle set always governs, whatever the load.
- R10: Threshold inputs are sampled only at a batch boundary: an acknowledge edge, or an edge where nothing is pending and the request is low. A change made while a batch is open does not affect that batch.
- R11: With no frame pending the timer stays at zero, so the request never rises without a pending frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_frame | input | 1 | One-cycle pulse per completed received frame |
| irq_ack | input | 1 | One-cycle acknowledge from software |
| coal_en | input | 1 | Coalescing enable; low gives one interrupt per frame |
| adapt_en | input | 1 | Lets the measured load pick the busy threshold set |
| idle_frames | input | 8 | Frame threshold for light traffic |
| idle_cycles | input | 16 | Cycle threshold for light traffic |
| busy_frames | input | 8 | Frame threshold for heavy traffic |
| busy_cycles | input | 16 | Cycle threshold for heavy traffic |
| irq | output | 1 | Level interrupt request |

## Verification
Each internal register leaves a visible trace on the request line. A pending count off by one moves the rising edge of irq by one frame. A timer that runs while idle, or restarts late, moves the timeout edge by at least one cycle. A wrong load decision changes the spacing of interrupts under steady traffic by the ratio of the two frame thresholds within one batch. All of these are caught because irq is compared each cycle against an independent model. Under steady flooding, the number of interrupts per 80 cycles is also counted, which exposes a stuck or inverted busy choice.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int FRM_W = 8;
    localparam int CYC_W = 16;

    typedef struct packed {
        logic [FRM_W-1:0] frames;
        logic [CYC_W-1:0] cycles;
    } thr_t;

    typedef enum logic {
        LOAD_IDLE = 1'b0,
        LOAD_BUSY = 1'b1
    } load_e;

    function automatic logic is_immediate(input logic coal_en, input thr_t t);
        return (!coal_en) || (t.frames <= FRM_W'(1)) || (t.cycles == '0);
    endfunction

endpackage

// File: rtl/rxc_load_monitor.sv
module rxc_load_monitor
    import rxc_pkg::*;
#(
    parameter int WIN_CYCLES = 32,
    parameter int HI_MARK    = 12,
    parameter int LO_MARK    = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_frame,
    output load_e load
);
    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam int FC_W  = $clog2(WIN_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam logic [FC_W-1:0]  HI_L     = FC_W'(HI_MARK);
    localparam logic [FC_W-1:0]  LO_L     = FC_W'(LO_MARK);

    logic [WIN_W-1:0] win_q;
    logic [FC_W-1:0]  cnt_q;
    logic [FC_W-1:0]  total;
    logic             wrap;
    load_e            load_q;

    assign wrap  = (win_q == WIN_LAST);
    assign total = cnt_q + FC_W'(rx_frame);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            cnt_q  <= '0;
            load_q <= LOAD_IDLE;
        end else if (wrap) begin
            win_q <= '0;
            cnt_q <= '0;
            if (total > HI_L)
                load_q <= LOAD_BUSY;
            else if (total < LO_L)
                load_q <= LOAD_IDLE;
        end else begin
            win_q <= win_q + WIN_W'(1);
            cnt_q <= total;
        end
    end

    assign load = load_q;

    // R8: the load decision only moves at the close of a window
    p_busy_enter_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(load_q == LOAD_BUSY) |-> $past(wrap));
    p_busy_leave_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(load_q == LOAD_BUSY) |-> $past(wrap));

endmodule

// File: rtl/rxc_thresh_sel.sv
module rxc_thresh_sel
    import rxc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  boundary,
    input  logic  adapt_en,
    input  load_e load,
    input  thr_t  idle_thr,
    input  thr_t  busy_thr,
    output thr_t  eff_thr
);
    thr_t act_q;
    thr_t pick;

    always_comb begin
        pick = idle_thr;
        if (adapt_en && (load == LOAD_BUSY))
            pick = busy_thr;
        eff_thr = boundary ? pick : act_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= '0;
        else
            act_q <= eff_thr;
    end

endmodule

// File: rtl/rxc_batch.sv
module rxc_batch
    import rxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_frame,
    input  logic irq_ack,
    input  logic coal_en,
    input  thr_t eff_thr,
    output logic boundary,
    output logic irq
);
    localparam logic [FRM_W-1:0] PEND_MAX = '1;
    localparam logic [CYC_W-1:0] TMR_MAX  = '1;

    logic [FRM_W-1:0] pend_q, p0, p1;
    logic [CYC_W-1:0] tmr_q, t0, t_inc;
    logic             irq_q, i0;
    logic             running, count_hit, time_hit, immediate;

    always_comb begin
        boundary  = irq_ack || ((pend_q == '0) && !irq_q);
        p0        = irq_ack ? '0 : pend_q;
        t0        = irq_ack ? '0 : tmr_q;
        i0        = irq_ack ? 1'b0 : irq_q;
        p1        = (rx_frame && (p0 != PEND_MAX)) ? p0 + FRM_W'(1) : p0;
        immediate = is_immediate(coal_en, eff_thr);
        count_hit = (p1 != '0) && (immediate || (p1 >= eff_thr.frames));
        running   = (p0 != '0) && !i0;
        t_inc     = (t0 == TMR_MAX) ? t0 : t0 + CYC_W'(1);
        time_hit  = running && (t_inc >= eff_thr.cycles);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            tmr_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= p1;
            tmr_q  <= running ? t_inc : '0;
            irq_q  <= i0 | count_hit | time_hit;
        end
    end

    assign irq = irq_q;

    // R5: an acknowledge leaves exactly the frame of its own cycle pending
    p_ack_restart_r5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> (pend_q == FRM_W'($past(rx_frame))));

    // R11: no pending frame, no elapsed time
    p_timer_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |-> (tmr_q == '0));

    // R10: an open batch keeps its thresholds until acknowledged
    p_thr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ((pend_q != '0) && !irq_q && !irq_ack) |=> (irq_ack || $stable(eff_thr)));

endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
    import rxc_pkg::*;
#(
    parameter int WIN_CYCLES = 32,
    parameter int HI_MARK    = 12,
    parameter int LO_MARK    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_frame,
    input  logic             irq_ack,
    input  logic             coal_en,
    input  logic             adapt_en,
    input  logic [FRM_W-1:0] idle_frames,
    input  logic [CYC_W-1:0] idle_cycles,
    input  logic [FRM_W-1:0] busy_frames,
    input  logic [CYC_W-1:0] busy_cycles,
    output logic             irq
);
    load_e load;
    thr_t  idle_thr, busy_thr, eff_thr;
    logic  boundary;

    assign idle_thr = '{frames: idle_frames, cycles: idle_cycles};
    assign busy_thr = '{frames: busy_frames, cycles: busy_cycles};

    rxc_load_monitor #(
        .WIN_CYCLES (WIN_CYCLES),
        .HI_MARK    (HI_MARK),
        .LO_MARK    (LO_MARK)
    ) u_load (
        .clk      (clk),
        .rst      (rst),
        .rx_frame (rx_frame),
        .load     (load)
    );

    rxc_thresh_sel u_sel (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .adapt_en (adapt_en),
        .load     (load),
        .idle_thr (idle_thr),
        .busy_thr (busy_thr),
        .eff_thr  (eff_thr)
    );

    rxc_batch u_batch (
        .clk      (clk),
        .rst      (rst),
        .rx_frame (rx_frame),
        .irq_ack  (irq_ack),
        .coal_en  (coal_en),
        .eff_thr  (eff_thr),
        .boundary (boundary),
        .irq      (irq)
    );

    // R4: the request is held until software acknowledges it
    p_irq_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack) |=> irq);

    // R6: with coalescing off a frame is signalled at once
    p_immediate_r6: assert property (@(posedge clk) disable iff (rst)
        (!coal_en && rx_frame) |=> irq);

endmodule

// File: tb/rx_irq_coalescer_tb_top.sv
module rx_irq_coalescer_tb_top;
    localparam int WIN = 32;
    localparam int HI  = 12;
    localparam int LO  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_frame = 1'b0, irq_ack = 1'b0, coal_en = 1'b1, adapt_en = 1'b0;
    logic [7:0]  idle_frames = 8'd4, busy_frames = 8'd8;
    logic [15:0] idle_cycles = 16'd20, busy_cycles = 16'd60;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    rx_irq_coalescer #(.WIN_CYCLES(WIN), .HI_MARK(HI), .LO_MARK(LO)) dut_i (
        .clk(clk), .rst(rst), .rx_frame(rx_frame), .irq_ack(irq_ack),
        .coal_en(coal_en), .adapt_en(adapt_en),
        .idle_frames(idle_frames), .idle_cycles(idle_cycles),
        .busy_frames(busy_frames), .busy_cycles(busy_cycles), .irq(irq));

    // behavioural reference model
    int m_pend = 0, m_tmr = 0, m_irq = 0, m_af = 0, m_ac = 0;
    int m_busy = 0, m_wc = 0, m_fc = 0;

    always @(posedge clk) begin
        int ef, ec, p0, t0, i0, p1, tinc, run, imm, tot;
        if (rst) begin
            m_pend = 0; m_tmr = 0; m_irq = 0; m_af = 0; m_ac = 0;
            m_busy = 0; m_wc = 0; m_fc = 0;
        end else begin
            if (irq_ack || (m_pend == 0 && m_irq == 0)) begin
                if (adapt_en && m_busy == 1) begin ef = busy_frames; ec = busy_cycles; end
                else begin ef = idle_frames; ec = idle_cycles; end
            end else begin
                ef = m_af; ec = m_ac;
            end
            m_af = ef; m_ac = ec;
            p0 = irq_ack ? 0 : m_pend;
            t0 = irq_ack ? 0 : m_tmr;
            i0 = irq_ack ? 0 : m_irq;
            p1 = (rx_frame && p0 < 255) ? p0 + 1 : p0;
            imm = (!coal_en || ef <= 1 || ec == 0) ? 1 : 0;
            run = (p0 > 0 && i0 == 0) ? 1 : 0;
            tinc = (t0 < 65535) ? t0 + 1 : t0;
            m_irq = (i0 == 1 || (p1 > 0 && (imm == 1 || p1 >= ef)) ||
                     (run == 1 && tinc >= ec)) ? 1 : 0;
            m_pend = p1;
            m_tmr = (run == 1) ? tinc : 0;
            if (m_wc == WIN - 1) begin
                tot = m_fc + (rx_frame ? 1 : 0);
                if (tot > HI) m_busy = 1;
                else if (tot < LO) m_busy = 0;
                m_fc = 0; m_wc = 0;
            end else begin
                m_fc = m_fc + (rx_frame ? 1 : 0);
                m_wc = m_wc + 1;
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycle = cycle + 1;
        if (!rst) begin
            checks = checks + 1;
            if (irq !== m_irq[0]) begin
                errors = errors + 1;
                $display("FAIL %s cycle %0d: irq actual %b expected %0d", cur_req, cycle, irq, m_irq);
            end
        end
    end

    task automatic chk(input string tag, input logic actual, input logic expected);
        checks = checks + 1;
        if (actual !== expected) begin
            errors = errors + 1;
            $display("FAIL %s: irq actual %b expected %b", tag, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame();
        rx_frame = 1'b1; @(negedge clk); rx_frame = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic flood(input int n, output int late_irqs);
        late_irqs = 0;
        rx_frame = 1'b1;
        for (int i = 0; i < n; i++) begin
            irq_ack = irq;
            if (i >= n - 80 && irq) late_irqs = late_irqs + 1;
            @(negedge clk);
        end
        rx_frame = 1'b0; irq_ack = 1'b0;
    endtask

    initial begin
        int n;
        tick(3);
        chk("R1 during reset", irq, 1'b0);
        rst = 1'b0;
        tick(1);
        chk("R1 after reset", irq, 1'b0);

        cur_req = "R2";
        for (int k = 0; k < 3; k++) begin frame(); tick(1); end
        chk("R2 below count", irq, 1'b0);
        frame();
        chk("R2 count reached", irq, 1'b1);

        cur_req = "R4";
        tick(10);
        chk("R4 held", irq, 1'b1);
        ack();
        chk("R4 cleared", irq, 1'b0);

        cur_req = "R11";
        tick(100);
        chk("R11 idle timer", irq, 1'b0);

        cur_req = "R3";
        frame();
        tick(19);
        chk("R3 before timeout", irq, 1'b0);
        tick(1);
        chk("R3 at timeout", irq, 1'b1);

        cur_req = "R5";
        rx_frame = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        rx_frame = 1'b0; irq_ack = 1'b0;
        chk("R5 ack cycle", irq, 1'b0);
        frame(); frame();
        chk("R5 three pending", irq, 1'b0);
        frame();
        chk("R5 ack frame counted", irq, 1'b1);
        ack();

        cur_req = "R6";
        coal_en = 1'b0;
        frame();
        chk("R6 disabled", irq, 1'b1);
        ack();
        coal_en = 1'b1;

        cur_req = "R7";
        idle_frames = 8'd1;
        frame();
        chk("R7 frames=1", irq, 1'b1);
        ack();
        idle_frames = 8'd4; idle_cycles = 16'd0;
        frame();
        chk("R7 cycles=0", irq, 1'b1);
        ack();
        idle_cycles = 16'd20;

        cur_req = "R10";
        frame(); frame();
        idle_frames = 8'd2;
        frame();
        chk("R10 mid-batch change ignored", irq, 1'b0);
        frame();
        chk("R10 old threshold", irq, 1'b1);
        ack();
        frame();
        chk("R10 new threshold pending", irq, 1'b0);
        frame();
        chk("R10 new threshold applied", irq, 1'b1);
        ack();
        idle_frames = 8'd4;

        cur_req = "R9";
        flood(160, n);
        checks = checks + 1;
        if (n != 20) begin
            errors = errors + 1;
            $display("FAIL R9 flood irq count actual %0d expected 20", n);
        end
        tick(100); ack(); tick(2);

        cur_req = "R8";
        adapt_en = 1'b1;
        flood(160, n);
        checks = checks + 1;
        if (n != 10) begin
            errors = errors + 1;
            $display("FAIL R8 busy irq count actual %0d expected 10", n);
        end
        for (int i = 0; i < 96; i++) begin
            rx_frame = (i % 4 == 0);
            irq_ack = irq;
            @(negedge clk);
        end
        rx_frame = 1'b0; irq_ack = 1'b0;
        tick(100); ack(); tick(2);
        for (int k = 0; k < 3; k++) frame();
        chk("R8 idle set after calm", irq, 1'b0);
        frame();
        chk("R8 idle threshold", irq, 1'b1);
        ack();
        tick(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule